// File: doc/BRIEF.md
# Guarded-Source Watchdog Timer

This block is a down-counting watchdog. It has a selectable prescaler and a flag that tells a cold start from a warm start. Software writes a restart register at intervals to keep the counter away from zero. If the counter reaches zero and a further count tick arrives, that is an underflow. The underflow either raises a one-cycle interrupt pulse or requests a system reset.

In normal mode the count tick comes from a CPU-clock tick divided by 16 or by 128. Counting pauses whenever the CPU is in wait mode, in stop mode or in hold state. A guarded configuration path, opened and closed through a write-enable bit, can switch the count source to a free-running internal oscillator tick. Once switched, the choice stays until the next power-on reset. From then on the counter ignores the CPU clock and the low-power requests, and software can no longer set the stop-request bit. Both clocks are modelled as enable ticks on one system clock.

Top module: `wdog_guarded`

## Requirements
- R1: After power-on reset, control reads 0x1F, the protect and both mode registers read 0x00, `irq` and `rst_req` are low, and the counter stays at its reload value until the first restart write.
- R2: A write to the restart register loads the counter with all ones (7FFFh for the default 15-bit width) and starts counting. The data value written has no effect.
- R3: Control bit 7 selects the prescaler. 0 gives one count per 16 CPU ticks and 1 gives one count per 128 CPU ticks. A restart write clears the prescaler phase.
- R4: Control bits 4..0 are read-only and return the five most significant counter bits. Bit 6 always reads 0, whatever value is written.
- R5: Control bit 5 is the warm flag. Power-on clears it, any control write sets it, and no write clears it.
- R6: The two mode registers accept writes only while bit 1 of the protect register (read with `rd_sel`=1) is 1. Otherwise a write leaves them unchanged.
- R7: With mode-1 bit 2 at 0, an underflow drives `irq` high for exactly one cycle, and the counter reloads all ones and keeps counting. From a restart, the underflow comes on count tick number 2^CNT_W.
- R8: With mode-1 bit 2 at 1, an underflow pulses `rst_req` for one cycle instead, and `irq` stays low.
- R9: With mode-2 bit 2 at 1 (guarded source), the counter decrements once per `osc_tick` and ignores `cpu_tick`.
- R10: Once mode-2 bit 2 is 1, it stays 1 until power-on reset. A later write of 0 is ignored.
- R11: Mode-1 bit 0 is the stop-request bit. In normal mode it is writable and reads back. In guarded-source mode a write of 1 is ignored and the bit reads 0.
- R12: In normal mode, counting freezes while `wait_req`, `stop_req` or `hold_req` is high or the stop-request bit is set. In guarded-source mode none of these pauses the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cpu_tick | input | 1 | CPU-clock enable tick |
| osc_tick | input | 1 | Internal-oscillator enable tick |
| wdata | input | 8 | Write data for all registers |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_restart | input | 1 | Restart register write strobe |
| wr_prot | input | 1 | Protect register write strobe |
| wr_mode1 | input | 1 | Mode-1 register write strobe |
| wr_mode2 | input | 1 | Mode-2 register write strobe |
| rd_sel | input | 2 | Read select: 0 control, 1 protect, 2 mode-1, 3 mode-2 |
| wait_req | input | 1 | CPU wait mode active |
| stop_req | input | 1 | CPU stop mode active |
| hold_req | input | 1 | Bus hold state active |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | One-cycle underflow interrupt |
| rst_req | output | 1 | One-cycle underflow reset request |

## Verification
A counter that loaded the wrong value or decremented at the wrong rate shows up in control bits 4..0. Those bits move one step every 2^(CNT_W-5) counts, so an error appears within one such window after a restart. An error in the prescaler phase or the underflow point moves the `irq` or `rst_req` pulse off its exact expected cycle. Lost or wrongly accepted configuration state shows up on the next read-back of a mode register. It also shows up as counting that continues or freezes against the low-power inputs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        RSEL_CTRL  = 2'd0,
        RSEL_PROT  = 2'd1,
        RSEL_MODE1 = 2'd2,
        RSEL_MODE2 = 2'd3
    } rsel_e;

    localparam int CTRL_PSEL_BIT = 7;
    localparam int CTRL_WARM_BIT = 5;
    localparam int PROT_WEN_BIT  = 1;
    localparam int MODE1_STOP_BIT = 0;
    localparam int MODE1_RST_BIT  = 2;
    localparam int MODE2_SRC_BIT  = 2;
    localparam int HI_BITS        = 5;

    typedef struct packed {
        logic warm;
        logic psel;
        logic wen;
        logic stop;
        logic rmode;
        logic gsrc;
    } cfg_s;

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    input  logic       wr_ctrl,
    input  logic       wr_prot,
    input  logic       wr_mode1,
    input  logic       wr_mode2,
    output cfg_s       cfg
);

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.warm = 1'b1;
            cfg_d.psel = wdata[CTRL_PSEL_BIT];
        end
        if (wr_prot) begin
            cfg_d.wen = wdata[PROT_WEN_BIT];
        end
        if (wr_mode1 && cfg_q.wen) begin
            cfg_d.rmode = wdata[MODE1_RST_BIT];
            cfg_d.stop  = wdata[MODE1_STOP_BIT] & ~cfg_q.gsrc;
        end
        if (wr_mode2 && cfg_q.wen) begin
            cfg_d.gsrc = cfg_q.gsrc | wdata[MODE2_SRC_BIT];
        end
        if (cfg_q.gsrc) begin
            cfg_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    a_r5_warm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.warm |=> cfg_q.warm);
    a_r10_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.gsrc |=> cfg_q.gsrc);
    a_r6_mode1_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode1 && !cfg_q.wen) |=> $stable(cfg_q.rmode));
    a_r6_mode2_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode2 && !cfg_q.wen) |=> $stable(cfg_q.gsrc));
    a_r11_stop_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.gsrc |=> !cfg_q.stop);

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int LO_LOG2 = 4,
    parameter int HI_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sel_hi,
    output logic pulse
);

    typedef struct packed {
        logic [HI_LOG2-1:0] cnt;
    } presc_s;

    presc_s pr_d, pr_q;
    logic   wrap;

    always_comb begin
        wrap  = sel_hi ? (&pr_q.cnt) : (&pr_q.cnt[LO_LOG2-1:0]);
        pulse = en && !clr && wrap;
        pr_d  = pr_q;
        if (clr) begin
            pr_d.cnt = '0;
        end else if (en) begin
            pr_d.cnt = pr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    a_r3_pulse_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             freeze,
    input  logic             rst_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             irq,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
        logic             rst;
    } ctr_s;

    ctr_s ct_d, ct_q;

    always_comb begin
        ct_d     = ct_q;
        ct_d.irq = 1'b0;
        ct_d.rst = 1'b0;
        if (restart) begin
            ct_d.cnt = RELOAD;
            ct_d.run = 1'b1;
        end else if (ct_q.run && tick && !freeze) begin
            if (ct_q.cnt == '0) begin
                ct_d.cnt = RELOAD;
                ct_d.irq = !rst_mode;
                ct_d.rst = rst_mode;
            end else begin
                ct_d.cnt = ct_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '{cnt: RELOAD, run: 1'b0, irq: 1'b0, rst: 1'b0};
        end else begin
            ct_q <= ct_d;
        end
    end

    assign cnt     = ct_q.cnt;
    assign running = ct_q.run;
    assign irq     = ct_q.irq;
    assign rst_req = ct_q.rst;

    a_r2_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == RELOAD) && running);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r8_rst_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(rst_mode) && !irq);
    a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !restart) |=> $stable(cnt));

endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int LO_LOG2 = 4,
    parameter int HI_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_tick,
    input  logic       osc_tick,
    input  logic [7:0] wdata,
    input  logic       wr_ctrl,
    input  logic       wr_restart,
    input  logic       wr_prot,
    input  logic       wr_mode1,
    input  logic       wr_mode2,
    input  logic [1:0] rd_sel,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       hold_req,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       rst_req
);

    cfg_s             cfg;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             presc_pulse;
    logic             freeze;
    logic             cnt_tick;
    logic             presc_en;
    logic [HI_BITS-1:0] cnt_hi;

    wdog_cfg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wdata),
        .wr_ctrl  (wr_ctrl),
        .wr_prot  (wr_prot),
        .wr_mode1 (wr_mode1),
        .wr_mode2 (wr_mode2),
        .cfg      (cfg)
    );

    always_comb begin
        freeze   = !cfg.gsrc && (wait_req || stop_req || hold_req || cfg.stop);
        presc_en = cpu_tick && running && !freeze;
        cnt_tick = cfg.gsrc ? osc_tick : presc_pulse;
    end

    wdog_presc #(
        .LO_LOG2 (LO_LOG2),
        .HI_LOG2 (HI_LOG2)
    ) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_restart),
        .en     (presc_en),
        .sel_hi (cfg.psel),
        .pulse  (presc_pulse)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_restart),
        .tick     (cnt_tick),
        .freeze   (freeze),
        .rst_mode (cfg.rmode),
        .cnt      (cnt),
        .running  (running),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    assign cnt_hi = cnt[CNT_W-1 -: HI_BITS];

    always_comb begin
        rdata = '0;
        case (rsel_e'(rd_sel))
            RSEL_CTRL: begin
                rdata[HI_BITS-1:0]   = cnt_hi;
                rdata[CTRL_WARM_BIT] = cfg.warm;
                rdata[CTRL_PSEL_BIT] = cfg.psel;
            end
            RSEL_PROT:  rdata[PROT_WEN_BIT] = cfg.wen;
            RSEL_MODE1: begin
                rdata[MODE1_STOP_BIT] = cfg.stop;
                rdata[MODE1_RST_BIT]  = cfg.rmode;
            end
            RSEL_MODE2: rdata[MODE2_SRC_BIT] = cfg.gsrc;
            default:    rdata = '0;
        endcase
    end

    a_r9_guarded_ignores_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gsrc && !osc_tick && !wr_restart) |=> $stable(cnt));

endmodule

// File: tb/test_wdog_guarded.sv
module test_wdog_guarded;

    localparam int PERIOD = 10;
    localparam int CW     = 10;
    localparam int RELOAD = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b1, osc_tick = 1'b1;
    logic [7:0] wdata = '0;
    logic       wr_ctrl = 0, wr_restart = 0, wr_prot = 0, wr_mode1 = 0, wr_mode2 = 0;
    logic [1:0] rd_sel = '0;
    logic       wait_req = 0, stop_req = 0, hold_req = 0;
    logic [7:0] rdata;
    logic       irq, rst_req;

    int n_chk = 0;
    int n_err = 0;
    logic [1:0] exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    wdog_guarded #(.CNT_W(CW)) i_wdog_guarded (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .osc_tick(osc_tick),
        .wdata(wdata), .wr_ctrl(wr_ctrl), .wr_restart(wr_restart), .wr_prot(wr_prot),
        .wr_mode1(wr_mode1), .wr_mode2(wr_mode2), .rd_sel(rd_sel),
        .wait_req(wait_req), .stop_req(stop_req), .hold_req(hold_req),
        .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rdata;
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wdata = d;
        case (which)
            0: wr_ctrl = 1;
            1: wr_restart = 1;
            2: wr_prot = 1;
            3: wr_mode1 = 1;
            default: wr_mode2 = 1;
        endcase
        @(negedge clk);
        {wr_ctrl, wr_restart, wr_prot, wr_mode1, wr_mode2} = '0;
    endtask

    // scoreboard monitor: 2'b01 interrupt, 2'b10 reset request
    always @(negedge clk) begin
        if (rst_n && (irq || rst_req)) begin
            if (exp_q.size() == 0) begin
                chk("R7/R8 unexpected pulse", {6'd0, rst_req, irq}, 8'h00);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk("R7/R8 pulse kind", {6'd0, rst_req, irq}, {6'd0, e});
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 8'h1F);
        rd(1, v); chk("R1 prot", v, 8'h00);
        rd(2, v); chk("R1 mode1", v, 8'h00);
        rd(3, v); chk("R1 mode2", v, 8'h00);
        chk("R1 outputs", {6'd0, rst_req, irq}, 8'h00);
        waitn(100);
        rd(0, v); chk("R1 idle before restart", v, 8'h1F);

        // R5 warm flag, R4 bit 6 reads zero
        wr(0, 8'h40);
        rd(0, v); chk("R5 R4 ctrl after write", v, 8'h3F);

        // R3 divide by 16
        wr(1, 8'h00);
        waitn(511); rd(0, v); chk("R3 div16 before step", v & 8'h1F, 8'h1F);
        waitn(1);   rd(0, v); chk("R3 R4 div16 step", v, 8'h3E);

        // R2 restart with arbitrary data reloads
        wr(1, 8'hA5);
        rd(0, v); chk("R2 reload", v & 8'h1F, 8'h1F);
        waitn(511); rd(0, v); chk("R2 before step", v & 8'h1F, 8'h1F);
        waitn(1);   rd(0, v); chk("R2 step", v & 8'h1F, 8'h1E);

        // R3 divide by 128
        wr(0, 8'h80);
        rd(0, v); chk("R3 R5 psel readback", v & 8'hE0, 8'hA0);
        wr(1, 8'h00);
        waitn(4095); rd(0, v); chk("R3 div128 before step", v & 8'h1F, 8'h1F);
        waitn(1);    rd(0, v); chk("R3 div128 step", v & 8'h1F, 8'h1E);

        // R12 wait freezes in normal mode
        wr(0, 8'h00);
        rd(0, v); chk("R5 warm kept", v & 8'hE0, 8'h20);
        wr(1, 8'h00);
        wait_req = 1;
        waitn(600); rd(0, v); chk("R12 frozen by wait", v & 8'h1F, 8'h1F);
        wait_req = 0;
        waitn(511); rd(0, v); chk("R12 resumes before step", v & 8'h1F, 8'h1F);
        waitn(1);   rd(0, v); chk("R12 resumes step", v & 8'h1F, 8'h1E);

        // R11 stop bit in normal mode, R12 stop bit freezes
        wr(2, 8'h02);
        rd(1, v); chk("R6 prot readback", v, 8'h02);
        wr(3, 8'h01);
        rd(2, v); chk("R11 stop bit accepted", v, 8'h01);
        wr(1, 8'h00);
        waitn(600); rd(0, v); chk("R12 frozen by stop bit", v & 8'h1F, 8'h1F);
        wr(3, 8'h00);

        // R6 locked writes
        wr(2, 8'h00);
        wr(3, 8'h04);
        rd(2, v); chk("R6 mode1 locked", v, 8'h00);
        wr(4, 8'h04);
        rd(3, v); chk("R6 mode2 locked", v, 8'h00);

        // R9 guarded source, R7 interrupt, R12 no freeze
        wr(2, 8'h02);
        wr(4, 8'h04);
        rd(3, v); chk("R9 mode2 set", v, 8'h04);
        wr(2, 8'h00);
        cpu_tick = 0; wait_req = 1; stop_req = 1; hold_req = 1;
        wr(1, 8'h00);
        exp_q.push_back(2'b01);
        waitn(31); rd(0, v); chk("R9 R12 osc count", v & 8'h1F, 8'h1F);
        waitn(1);  rd(0, v); chk("R9 R12 osc step", v & 8'h1F, 8'h1E);
        waitn(RELOAD - 32);
        chk("R7 no early irq", {7'd0, irq}, 8'h00);
        rd(0, v); chk("R7 at zero", v & 8'h1F, 8'h00);
        waitn(1);
        chk("R7 irq pulse", {6'd0, rst_req, irq}, 8'h01);
        rd(0, v); chk("R7 reload", v & 8'h1F, 8'h1F);
        waitn(1);
        chk("R7 irq one cycle", {7'd0, irq}, 8'h00);

        // R10 sticky, R11 stop blocked, R8 reset mode
        wr(2, 8'h02);
        wr(4, 8'h00);
        rd(3, v); chk("R10 src sticky", v, 8'h04);
        wr(3, 8'h05);
        rd(2, v); chk("R11 stop ignored R8 rmode set", v, 8'h04);
        wr(2, 8'h00);
        wr(1, 8'h00);
        exp_q.push_back(2'b10);
        waitn(RELOAD);
        chk("R8 no early rst", {7'd0, rst_req}, 8'h00);
        waitn(1);
        chk("R8 rst pulse", {6'd0, rst_req, irq}, 8'h02);
        waitn(2);
        chk("R7 R8 scoreboard drained", 8'(exp_q.size()), 8'h00);

        summary();
        $finish;
    end

endmodule